// File: doc/BRIEF.md
# Pixel Framebuffer Clear and Sprite Blit Engine

This engine services a 64x32 monochrome framebuffer that can only be reached one pixel at a time through a 1-bit synchronous read/write port. There is no bulk-write path. A single start strobe launches one of two multi-cycle operations. A clear operation walks every pixel and writes zero to it. A draw operation fetches sprite rows from a byte-wide synchronous memory and XORs each 8-pixel row onto the screen at a given origin. While drawing, it records whether any lit pixel was switched off.

Both memories answer a read one cycle after the address is presented. The engine therefore works through fixed phase states. The timing of each operation depends only on its opcode and row count. When the engine finishes, it raises a one-cycle completion pulse. A sequencer uses that pulse to pick up the collision result.

Top module: `pixel_blit_engine`

## Requirements
- R1: After reset, busy, done, collision and the framebuffer write enable are all 0.
- R2: A strobe with opcode 0 (clear) writes 0 to all 2048 pixels, one per cycle. Busy is high for the 2048 cycles after the strobe edge. Done is high in cycle 2049.
- R3: Clear visits pixels in ascending order of the 11-bit index {X,Y}, where X is bits 10:5 and Y is bits 4:0. Y advances first, starting at (0,0) and ending at (63,31).
- R4: A strobe with opcode 1 (draw) reads sprite row r from memory address base+r. It XORs bit 7-c of that byte onto pixel (x+c, y+r) for columns c = 0..7, so the MSB is the leftmost pixel.
- R5: A draw of N rows (N = 1..15) keeps busy high for 18*N cycles and raises done in cycle 18*N+1. A row count of 0 raises done in cycle 1 and writes nothing.
- R6: The collision output is 1 exactly when the draw turned off at least one pixel that was lit. It is valid while done is high and holds its value until the next accepted strobe.
- R7: Pixel coordinates wrap modulo 64 in X and modulo 32 in Y.
- R8: A sprite bit of 0 produces no framebuffer write and leaves that pixel unchanged, but it uses the same two cycles as a 1 bit. The write enable is only ever high while busy.
- R9: A start strobe is ignored while busy is high or during the done cycle. Busy rises only in the cycle after a strobe.
- R10: Done lasts exactly one cycle and is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe, accepted only when idle |
| startOp | input | 1 | 0 = clear, 1 = draw |
| startX | input | 6 | Draw origin X |
| startY | input | 5 | Draw origin Y |
| startRows | input | 4 | Sprite row count |
| startBase | input | 12 | Sprite base address |
| memAddr | output | 12 | Sprite memory read address |
| memData | input | 8 | Sprite memory read data, one cycle after the address |
| fbAddrX | output | 6 | Framebuffer pixel X |
| fbAddrY | output | 5 | Framebuffer pixel Y |
| fbWrEn | output | 1 | Framebuffer write enable |
| fbWrData | output | 1 | Framebuffer write data |
| fbRdData | input | 1 | Framebuffer read data, one cycle after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | A lit pixel was turned off by the last draw |

## Verification
Cycle 0 is the clock edge that samples the strobe. Done is due in cycle 2049 after a clear, in cycle 18*N+1 after a draw of N rows, and in cycle 1 for a zero-row draw. Busy must be high in every cycle before that.

The bench samples on the falling edge and counts cycles from the strobe edge. It compares the count against these formulas and checks busy in every sampled cycle. It records each framebuffer write as it happens, which lets it check the clear order and the number of writes per draw. Once done has been seen, the bench compares the whole framebuffer with a model it computes itself. It also checks that done has dropped one cycle later and that the collision output still holds its value a few cycles after that.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FETCH,
    ST_LATCH,
    ST_PRD,
    ST_PWR,
    ST_FIN
  } blitState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic clearPhase;
    logic rowLatch;
    logic readPhase;
    logic writePhase;
  } blitCtl_t;

  localparam logic OP_CLEAR = 1'b0;
  localparam logic OP_DRAW  = 1'b1;

endpackage

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int X_W      = 6,
  parameter int Y_W      = 5,
  parameter int ROW_W    = 4,
  parameter int SPRITE_W = 8,
  parameter int MEM_AW   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  blitCtl_t            ctl,
  input  logic [X_W-1:0]      startX,
  input  logic [Y_W-1:0]      startY,
  input  logic [ROW_W-1:0]    startRows,
  input  logic [MEM_AW-1:0]   startBase,
  input  logic [SPRITE_W-1:0] memData,
  input  logic                fbRdData,
  output logic [MEM_AW-1:0]   memAddr,
  output logic [X_W-1:0]      fbAddrX,
  output logic [Y_W-1:0]      fbAddrY,
  output logic                fbWrEn,
  output logic                fbWrData,
  output logic                collision,
  output logic                clrLast,
  output logic                colLast,
  output logic                rowLast
);

  localparam int COL_W = $clog2(SPRITE_W);
  localparam int POS_W = X_W + Y_W;

  logic [POS_W-1:0]    clrPos;
  logic [X_W-1:0]      origX;
  logic [Y_W-1:0]      origY;
  logic [ROW_W-1:0]    rowCnt;
  logic [ROW_W-1:0]    rowIdx;
  logic [COL_W-1:0]    colIdx;
  logic [MEM_AW-1:0]   baseAddr;
  logic [SPRITE_W-1:0] rowBits;
  logic                collReg;

  logic                spriteBit;
  logic [X_W-1:0]      pixX;
  logic [Y_W-1:0]      pixY;
  logic [ROW_W:0]      rowNext;

  // X in the upper bits, so Y is the fast-moving coordinate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrPos   <= '0;
      origX    <= '0;
      origY    <= '0;
      rowCnt   <= '0;
      rowIdx   <= '0;
      colIdx   <= '0;
      baseAddr <= '0;
      rowBits  <= '0;
      collReg  <= 1'b0;
    end else begin
      if (ctl.loadCmd) begin
        clrPos   <= '0;
        origX    <= startX;
        origY    <= startY;
        rowCnt   <= startRows;
        rowIdx   <= '0;
        colIdx   <= '0;
        baseAddr <= startBase;
        collReg  <= 1'b0;
      end
      if (ctl.clearPhase) begin
        clrPos <= clrPos + 1'b1;
      end
      if (ctl.rowLatch) begin
        rowBits <= memData;
      end
      if (ctl.writePhase) begin
        if (spriteBit && fbRdData) begin
          collReg <= 1'b1;
        end
        colIdx <= colIdx + 1'b1;
        if (colLast) begin
          rowIdx <= rowIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    spriteBit = rowBits[COL_W'(SPRITE_W - 1) - colIdx];
    pixX      = origX + X_W'(colIdx);
    pixY      = origY + Y_W'(rowIdx);
    rowNext   = {1'b0, rowIdx} + 1'b1;
    clrLast   = &clrPos;
    colLast   = (colIdx == COL_W'(SPRITE_W - 1));
    rowLast   = (rowNext == {1'b0, rowCnt});
    memAddr   = baseAddr + MEM_AW'(rowIdx);
    if (ctl.clearPhase) begin
      fbAddrX = clrPos[POS_W-1:Y_W];
      fbAddrY = clrPos[Y_W-1:0];
    end else begin
      fbAddrX = pixX;
      fbAddrY = pixY;
    end
    fbWrEn    = ctl.clearPhase | (ctl.writePhase & spriteBit);
    fbWrData  = ctl.clearPhase ? 1'b0 : ~fbRdData;
    collision = collReg;
  end

endmodule

// File: rtl/blit_control.sv
module blit_control
  import blit_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             startOp,
  input  logic [ROW_W-1:0] startRows,
  input  logic             clrLast,
  input  logic             colLast,
  input  logic             rowLast,
  output blitCtl_t         ctl,
  output logic             busy,
  output logic             done
);

  blitState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          ctl.loadCmd = 1'b1;
          if (startOp == OP_CLEAR)    stateNext = ST_CLEAR;
          else if (startRows == '0)   stateNext = ST_FIN;
          else                        stateNext = ST_FETCH;
        end
      end
      ST_CLEAR: begin
        ctl.clearPhase = 1'b1;
        if (clrLast) stateNext = ST_FIN;
      end
      ST_FETCH: stateNext = ST_LATCH;
      ST_LATCH: begin
        ctl.rowLatch = 1'b1;
        stateNext    = ST_PRD;
      end
      ST_PRD: begin
        ctl.readPhase = 1'b1;
        stateNext     = ST_PWR;
      end
      ST_PWR: begin
        ctl.writePhase = 1'b1;
        if (!colLast)     stateNext = ST_PRD;
        else if (rowLast) stateNext = ST_FIN;
        else              stateNext = ST_FETCH;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_FIN);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/pixel_blit_engine.sv
module pixel_blit_engine
  import blit_pkg::*;
#(
  parameter int X_W      = 6,
  parameter int Y_W      = 5,
  parameter int ROW_W    = 4,
  parameter int SPRITE_W = 8,
  parameter int MEM_AW   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  input  logic                startOp,
  input  logic [X_W-1:0]      startX,
  input  logic [Y_W-1:0]      startY,
  input  logic [ROW_W-1:0]    startRows,
  input  logic [MEM_AW-1:0]   startBase,
  output logic [MEM_AW-1:0]   memAddr,
  input  logic [SPRITE_W-1:0] memData,
  output logic [X_W-1:0]      fbAddrX,
  output logic [Y_W-1:0]      fbAddrY,
  output logic                fbWrEn,
  output logic                fbWrData,
  input  logic                fbRdData,
  output logic                busy,
  output logic                done,
  output logic                collision
);

  blitCtl_t ctl;
  logic     clrLast, colLast, rowLast;

  blit_control #(.ROW_W(ROW_W)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .startOp   (startOp),
    .startRows (startRows),
    .clrLast   (clrLast),
    .colLast   (colLast),
    .rowLast   (rowLast),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  blit_datapath #(
    .X_W(X_W), .Y_W(Y_W), .ROW_W(ROW_W), .SPRITE_W(SPRITE_W), .MEM_AW(MEM_AW)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startX   (startX),
    .startY   (startY),
    .startRows(startRows),
    .startBase(startBase),
    .memData  (memData),
    .fbRdData (fbRdData),
    .memAddr  (memAddr),
    .fbAddrX  (fbAddrX),
    .fbAddrY  (fbAddrY),
    .fbWrEn   (fbWrEn),
    .fbWrData (fbWrData),
    .collision(collision),
    .clrLast  (clrLast),
    .colLast  (colLast),
    .rowLast  (rowLast)
  );

endmodule

// File: rtl/blit_checker.sv
module blit_checker (
  input logic clk,
  input logic rstN,
  input logic startValid,
  input logic fbWrEn,
  input logic busy,
  input logic done,
  input logic collision
);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startValid));

  assert_write_only_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    fbWrEn |-> busy);

  assert_coll_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(collision));

endmodule

bind pixel_blit_engine blit_checker i_blit_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startValid(startValid),
  .fbWrEn    (fbWrEn),
  .busy      (busy),
  .done      (done),
  .collision (collision)
);

// File: tb/test_pixel_blit_engine.sv
module test_pixel_blit_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startOp = 1'b0;
  logic [5:0]  startX = '0;
  logic [4:0]  startY = '0;
  logic [3:0]  startRows = '0;
  logic [11:0] startBase = '0;
  logic [11:0] memAddr;
  logic [7:0]  memData;
  logic [5:0]  fbAddrX;
  logic [4:0]  fbAddrY;
  logic        fbWrEn, fbWrData, fbRdData;
  logic        busy, done, collision;

  logic [7:0]  mem   [0:255];
  logic        fb    [0:2047];
  logic        expFb [0:2047];

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  pixel_blit_engine i_pixel_blit_engine (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .startX(startX), .startY(startY), .startRows(startRows), .startBase(startBase),
    .memAddr(memAddr), .memData(memData), .fbAddrX(fbAddrX), .fbAddrY(fbAddrY),
    .fbWrEn(fbWrEn), .fbWrData(fbWrData), .fbRdData(fbRdData),
    .busy(busy), .done(done), .collision(collision)
  );

  // Synchronous memories: one-cycle read latency, old data on write
  always @(posedge clk) begin
    memData  <= mem[memAddr[7:0]];
    fbRdData <= fb[{fbAddrX, fbAddrY}];
    if (fbWrEn) fb[{fbAddrX, fbAddrY}] <= fbWrData;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // Pulse a start and follow the run up to done; returns the done cycle
  task automatic runOp(input logic op, input int x, input int y, input int rows,
                       input int base, output int cycles, output int writes,
                       output int orderErrs, output int busyErrs);
    @(negedge clk);
    startOp = op; startX = 6'(x); startY = 5'(y);
    startRows = 4'(rows); startBase = 12'(base); startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    cycles = 1; writes = 0; orderErrs = 0; busyErrs = 0;
    while (!done && cycles < 5000) begin
      if (!busy) busyErrs++;
      if (fbWrEn) begin
        if (op == 1'b0 && ({fbAddrX, fbAddrY} != 11'(writes) || fbWrData)) orderErrs++;
        writes++;
      end
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic compareFb(input string req);
    int bad = 0;
    for (int i = 0; i < 2048; i++) if (fb[i] !== expFb[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic modelDraw(input int x, input int y, input int rows, input int base,
                           output int coll, output int ones);
    coll = 0; ones = 0;
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < 8; c++) begin
        if (mem[(base + r) % 256][7 - c]) begin
          int idx = ((x + c) % 64) * 32 + ((y + r) % 32);
          if (expFb[idx]) coll = 1;
          expFb[idx] = ~expFb[idx];
          ones++;
        end
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    check(collision == 0 && fbWrEn == 0, "R1 coll/wren", {collision, fbWrEn}, 0);
  endtask

  task automatic testClear();
    int cyc, wr, ord, be;
    for (int i = 0; i < 2048; i++) begin fb[i] = 1'b1; expFb[i] = 1'b0; end
    runOp(1'b0, 0, 0, 0, 0, cyc, wr, ord, be);
    check(cyc == 2049, "R2 clear done cycle", cyc, 2049);
    check(be == 0, "R2 busy during clear", be, 0);
    check(wr == 2048, "R2 clear write count", wr, 2048);
    check(ord == 0, "R3 clear order/data", ord, 0);
    @(negedge clk);
    check(done == 0, "R10 done one cycle", done, 0);
    compareFb("R2 frame zeroed");
  endtask

  task automatic testDraw(input int x, input int y, input int rows, input int base,
                          input string req);
    int cyc, wr, ord, be, coll, ones;
    logic collAtDone;
    modelDraw(x, y, rows, base, coll, ones);
    runOp(1'b1, x, y, rows, base, cyc, wr, ord, be);
    collAtDone = collision;
    check(cyc == 18 * rows + 1, {req, " R5 done cycle"}, cyc, 18 * rows + 1);
    check(be == 0, {req, " R5 busy"}, be, 0);
    check(wr == ones, {req, " R8 write count"}, wr, ones);
    check(int'(collAtDone) == coll, {req, " R6 collision"}, collAtDone, coll);
    @(negedge clk);
    check(done == 0, {req, " R10 done width"}, done, 0);
    repeat (3) @(negedge clk);
    check(int'(collision) == coll, {req, " R6 collision held"}, collision, coll);
    compareFb({req, " R4 frame"});
  endtask

  task automatic testIgnoredStart();
    int cyc = 1;
    for (int i = 0; i < 2048; i++) begin fb[i] = 1'b1; expFb[i] = 1'b0; end
    @(negedge clk);
    startOp = 1'b0; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    repeat (9) begin @(negedge clk); cyc++; end
    startOp = 1'b1; startX = 6'd3; startY = 5'd3; startRows = 4'd2;
    startBase = 12'd16; startValid = 1'b1;
    @(negedge clk); cyc++;
    startValid = 1'b0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    check(cyc == 2049, "R9 strobe while busy ignored", cyc, 2049);
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    check(busy == 0, "R9 strobe during done ignored", busy, 0);
    compareFb("R9 frame after ignored strobes");
  endtask

  initial begin
    #(200000 * 8);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37) + 11);
    mem[16] = 8'hF0; mem[17] = 8'h3C; mem[18] = 8'hFF;
    mem[32] = 8'h81; mem[33] = 8'h00;
    mem[48] = 8'hFF; mem[49] = 8'hA5; mem[50] = 8'hFF; mem[51] = 8'h5A;
    for (int i = 0; i < 2048; i++) begin fb[i] = 1'b0; expFb[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testClear();
    testDraw(10, 5, 3, 16, "first draw");
    testDraw(10, 5, 3, 16, "redraw collides");
    testDraw(20, 8, 2, 32, "sparse R8");
    testDraw(60, 30, 4, 48, "edge wrap R7");
    testDraw(60, 30, 4, 48, "edge wrap undo R7");
    testDraw(0, 0, 0, 16, "zero rows R5");
    testDraw(7, 1, 15, 100, "tall sprite");
    testIgnoredStart();
    finishRun();
  end

endmodule